// File: doc/BRIEF.md
# ROM Signature Self-Test Sequencer

This block runs a built-in self-test on command. A one-cycle start pulse carries a 32-bit result pointer. Three checks then run in a fixed order. First, every word of an internal ROM is folded into a 16-bit multiple-input signature register, and the final signature is compared with a known-good constant. Second, a bank of internal registers is written with two complementary patterns and read back after each write. Third, a request goes to a serial subsystem, and the block waits a bounded time for that subsystem's pass/fail answer.

When the checks are done, the block issues a memory write. The write sends one 32-bit result word to the pointer, aligned down to 16 bytes. The result word holds the raw signature and a set of fail flags. A done pulse follows once the write has been accepted.

The states are ST_IDLE, ST_ROM_RD, ST_ROM_CMP, ST_REG_WR, ST_REG_RD, ST_DIAG, ST_WRITE and ST_DONE. The transitions are:
- ST_IDLE to ST_ROM_RD on start.
- ST_ROM_RD to ST_ROM_CMP after the last ROM address.
- ST_ROM_CMP to ST_REG_WR.
- ST_REG_WR to ST_REG_RD.
- ST_REG_RD back to ST_REG_WR after the first pattern, or to ST_DIAG after the second.
- ST_DIAG to ST_WRITE on acknowledge or timeout.
- ST_WRITE to ST_DONE on write acknowledge.
- ST_DONE to ST_IDLE.

Top module: `rom_selftest_seq`

## Requirements
- R1: After reset, `diag_req_o`, `wr_req_o` and `done_o` are low. A start pulse is taken only in the idle state, and it latches `ptr_i`.
- R2: ROM words are read at addresses 0 to ROM_DEPTH-1 in ascending order, one per cycle. Each word goes into a signature register seeded to 16'hFFFF. The update is next = {s[14:0],0} XOR (s[15] ? 16'h1021 : 0) XOR word, which is the polynomial x^16+x^12+x^5+1. The final value appears in bits 31:16 of the result word.
- R3: Bit 2 of the result word is set exactly when the final signature differs from GOLD_SIG.
- R4: Every register in the bank is written with 16'h5555 and compared, then written with 16'hAAAA and compared. Bit 3 is set if any comparison mismatches.
- R5: `diag_req_o` is held high until `diag_ack_i` is seen. The value of `diag_fail_i` in that cycle is recorded in bit 5.
- R6: Suppose no acknowledge arrives during the first DIAG_TMO (1024) cycles of the request. Then the request drops, bit 5 is set, and any later acknowledge is ignored. An acknowledge in the 1024th cycle is still accepted.
- R7: Bit 12 is the OR of bits 2, 3 and 5. All other bits in 15:0 are zero.
- R8: `wr_req_o` stays high, with `wr_addr_o` and `wr_data_o` stable, until `wr_ack_i`. `wr_addr_o` is the latched pointer with bits 3:0 forced to zero.
- R9: `done_o` is a one-cycle pulse in the cycle after the cycle in which `wr_req_o` and `wr_ack_i` were both high.
- R10: A start pulse while a test is running is ignored. Neither the pointer nor the schedule changes.
- R11: The checks run in order: ROM, then registers, then diagnose. `diag_req_o` first goes high ROM_DEPTH+5 clock edges after the edge that accepts start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| ptr_i | input | 32 | Result pointer, sampled with start |
| diag_req_o | output | 1 | Diagnose request to the serial subsystem |
| diag_ack_i | input | 1 | Diagnose answer valid |
| diag_fail_i | input | 1 | Diagnose answer: 1 means fail |
| wr_req_o | output | 1 | Result write request |
| wr_addr_o | output | 32 | Result write address, 16-byte aligned |
| wr_data_o | output | 32 | Result word |
| wr_ack_i | input | 1 | Result write accepted |
| done_o | output | 1 | Test finished pulse |

## Verification
The ROM and register failures cannot be provoked from the ports, because the ROM and the register bank are internal. The bench therefore builds a second instance next to the first and drives both in lockstep with the same stimulus. This second instance has a golden constant that differs in one bit and a register bit stuck at zero, so both of those fail flags are seen on its result word. The diagnose timeout edge is the other hard case. Acknowledges are placed exactly 1023 and 1024 cycles into the request, and one run never answers at all. Together these show the last accepted cycle, the first rejected one, and that a late answer is ignored.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
    localparam int SIG_W    = 16;
    localparam logic [SIG_W-1:0] SIG_POLY = 16'h1021;
    localparam logic [SIG_W-1:0] SIG_SEED = 16'hFFFF;
    localparam int FLAG_ROM  = 2;
    localparam int FLAG_REG  = 3;
    localparam int FLAG_DIAG = 5;
    localparam int FLAG_ANY  = 12;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ROM_RD, ST_ROM_CMP, ST_REG_WR,
        ST_REG_RD, ST_DIAG, ST_WRITE, ST_DONE
    } st_e;
endpackage

// File: rtl/rom_model.sv
module rom_model #(
    parameter int ROM_DEPTH = 64,
    parameter int ROM_SALT  = 16'h3C5A,
    localparam int AW = $clog2(ROM_DEPTH)
) (
    input  logic [AW-1:0] addr,
    output logic [15:0]   word
);
    localparam logic [31:0] MUL = 32'h0000_9E37;
    logic [31:0] prod;
    always_comb begin
        prod = 32'(addr) * MUL;
        word = prod[15:0] ^ 16'(ROM_SALT);
    end
endmodule

// File: rtl/sig_misr.sv
module sig_misr
    import selftest_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             en,
    input  logic [SIG_W-1:0] din,
    output logic [SIG_W-1:0] sig
);
    logic [SIG_W-1:0] nxt;
    always_comb begin
        nxt = {sig[SIG_W-2:0], 1'b0} ^ (sig[SIG_W-1] ? SIG_POLY : '0) ^ din;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sig <= SIG_SEED;
        else if (init) sig <= SIG_SEED;
        else if (en)   sig <= nxt;
    end
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
    parameter int REG_COUNT = 4,
    parameter int REG_W     = 16,
    parameter int REG_STUCK = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] pat,
    output logic             mismatch
);
    logic [REG_W-1:0] regs [REG_COUNT];
    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        if (i == 0) begin : g_stuck
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  regs[i] <= '0;
                else if (we) regs[i] <= wdata & ~REG_W'(REG_STUCK);
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  regs[i] <= '0;
                else if (we) regs[i] <= wdata;
            end
        end
    end
    always_comb begin
        mismatch = 1'b0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (regs[i] != pat) mismatch = 1'b1;
        end
    end
endmodule

// File: rtl/rom_selftest_seq.sv
module rom_selftest_seq
    import selftest_pkg::*;
#(
    parameter int ROM_DEPTH = 64,
    parameter int ROM_SALT  = 16'h3C5A,
    parameter int GOLD_SIG  = 16'h0000,
    parameter int REG_COUNT = 4,
    parameter int REG_W     = 16,
    parameter int REG_STUCK = 0,
    parameter int DIAG_TMO  = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [31:0] ptr_i,
    output logic        diag_req_o,
    input  logic        diag_ack_i,
    input  logic        diag_fail_i,
    output logic        wr_req_o,
    output logic [31:0] wr_addr_o,
    output logic [31:0] wr_data_o,
    input  logic        wr_ack_i,
    output logic        done_o
);
    localparam int AW = $clog2(ROM_DEPTH);
    localparam int TW = $clog2(DIAG_TMO) + 1;
    localparam logic [AW-1:0] ADDR_LAST = AW'(ROM_DEPTH - 1);
    localparam logic [TW-1:0] TMR_LAST  = TW'(DIAG_TMO - 1);
    localparam logic [REG_W-1:0] PAT_A  = {(REG_W/2){2'b01}};

    st_e state, state_nxt;
    logic [31:0]      ptr_q;
    logic [AW-1:0]    addr_q;
    logic             pass_q;
    logic [TW-1:0]    tmr_q;
    logic             rom_fail_q, reg_fail_q, diag_fail_q;
    logic [15:0]      rom_word;
    logic [SIG_W-1:0] sig;
    logic             reg_mis;
    logic [REG_W-1:0] pat;
    logic             take_start;

    assign take_start = (state == ST_IDLE) && start_i;
    assign pat        = pass_q ? ~PAT_A : PAT_A;

    rom_model #(.ROM_DEPTH(ROM_DEPTH), .ROM_SALT(ROM_SALT)) u_rom (
        .addr(addr_q), .word(rom_word)
    );

    sig_misr u_misr (
        .clk(clk), .rst_n(rst_n), .init(take_start),
        .en(state == ST_ROM_RD), .din(rom_word), .sig(sig)
    );

    reg_bank #(.REG_COUNT(REG_COUNT), .REG_W(REG_W), .REG_STUCK(REG_STUCK)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(state == ST_REG_WR),
        .wdata(pat), .pat(pat), .mismatch(reg_mis)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (start_i) state_nxt = ST_ROM_RD;
            ST_ROM_RD:  if (addr_q == ADDR_LAST) state_nxt = ST_ROM_CMP;
            ST_ROM_CMP: state_nxt = ST_REG_WR;
            ST_REG_WR:  state_nxt = ST_REG_RD;
            ST_REG_RD:  state_nxt = pass_q ? ST_DIAG : ST_REG_WR;
            ST_DIAG:    if (diag_ack_i || tmr_q == TMR_LAST) state_nxt = ST_WRITE;
            ST_WRITE:   if (wr_ack_i) state_nxt = ST_DONE;
            ST_DONE:    state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q       <= '0;
            addr_q      <= '0;
            pass_q      <= 1'b0;
            tmr_q       <= '0;
            rom_fail_q  <= 1'b0;
            reg_fail_q  <= 1'b0;
            diag_fail_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start_i) begin
                    ptr_q       <= ptr_i;
                    addr_q      <= '0;
                    pass_q      <= 1'b0;
                    tmr_q       <= '0;
                    rom_fail_q  <= 1'b0;
                    reg_fail_q  <= 1'b0;
                    diag_fail_q <= 1'b0;
                end
                ST_ROM_RD:  addr_q <= addr_q + 1'b1;
                ST_ROM_CMP: rom_fail_q <= (sig != SIG_W'(GOLD_SIG));
                ST_REG_WR:  ;
                ST_REG_RD: begin
                    reg_fail_q <= reg_fail_q | reg_mis;
                    pass_q     <= 1'b1;
                end
                ST_DIAG: begin
                    if (diag_ack_i)             diag_fail_q <= diag_fail_i;
                    else if (tmr_q == TMR_LAST) diag_fail_q <= 1'b1;
                    else                        tmr_q <= tmr_q + 1'b1;
                end
                ST_WRITE, ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        diag_req_o = 1'b0;
        wr_req_o   = 1'b0;
        done_o     = 1'b0;
        wr_addr_o  = {ptr_q[31:4], 4'b0000};
        wr_data_o  = '0;
        wr_data_o[31:16]     = sig;
        wr_data_o[FLAG_ROM]  = rom_fail_q;
        wr_data_o[FLAG_REG]  = reg_fail_q;
        wr_data_o[FLAG_DIAG] = diag_fail_q;
        wr_data_o[FLAG_ANY]  = rom_fail_q | reg_fail_q | diag_fail_q;
        unique case (state)
            ST_DIAG:  diag_req_o = 1'b1;
            ST_WRITE: wr_req_o   = 1'b1;
            ST_DONE:  done_o     = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/selftest_chk.sv
module selftest_chk #(
    parameter int DIAG_TMO = 1024
) (
    input logic        clk,
    input logic        rst_n,
    input logic        diag_req_o,
    input logic        diag_ack_i,
    input logic        wr_req_o,
    input logic        wr_ack_i,
    input logic [31:0] wr_addr_o,
    input logic [31:0] wr_data_o,
    input logic        done_o
);
    localparam int CW = $clog2(DIAG_TMO) + 2;
    logic [CW-1:0] req_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          req_cnt <= '0;
        else if (diag_req_o) req_cnt <= req_cnt + 1'b1;
        else                 req_cnt <= '0;
    end

    // R5
    diag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        diag_req_o && !diag_ack_i && (req_cnt < CW'(DIAG_TMO - 1)) |=> diag_req_o);
    // R6
    diag_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        diag_req_o |-> req_cnt < CW'(DIAG_TMO));
    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_data_o) && $stable(wr_addr_o));
    // R8
    wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> wr_addr_o[3:0] == 4'h0);
    // R7
    flag_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (wr_data_o[12] == (wr_data_o[2] | wr_data_o[3] | wr_data_o[5]))
                     && ((wr_data_o[15:0] & 16'hEFD3) == 16'h0000));
    // R9
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(wr_req_o && wr_ack_i));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R11
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({diag_req_o, wr_req_o, done_o}));
endmodule

bind rom_selftest_seq selftest_chk #(.DIAG_TMO(DIAG_TMO)) u_chk (
    .clk(clk), .rst_n(rst_n), .diag_req_o(diag_req_o), .diag_ack_i(diag_ack_i),
    .wr_req_o(wr_req_o), .wr_ack_i(wr_ack_i), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .done_o(done_o)
);

// File: tb/sim_rom_selftest_seq.sv
module sim_rom_selftest_seq;
    localparam int DEPTH = 64;
    localparam int SALT  = 16'h3C5A;
    localparam int TMO   = 1024;

    function automatic logic [15:0] calc_sig();
        logic [15:0] s = 16'hFFFF;
        for (int a = 0; a < DEPTH; a++) begin
            logic [15:0] w = 16'((a * 40503) % 65536) ^ 16'(SALT);
            s = {s[14:0], 1'b0} ^ (s[15] ? 16'h1021 : 16'h0000) ^ w;
        end
        return s;
    endfunction
    localparam logic [15:0] GOLD = calc_sig();

    logic clk = 0, rst_n = 0, start = 0, dack = 0, dfail = 0, wack = 0;
    logic [31:0] ptr = '0;
    logic dreq_a, wreq_a, done_a, dreq_b, wreq_b, done_b;
    logic [31:0] waddr_a, wdata_a, waddr_b, wdata_b;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    rom_selftest_seq #(.ROM_DEPTH(DEPTH), .ROM_SALT(SALT), .GOLD_SIG(int'(GOLD)),
                       .DIAG_TMO(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ptr_i(ptr),
        .diag_req_o(dreq_a), .diag_ack_i(dack), .diag_fail_i(dfail),
        .wr_req_o(wreq_a), .wr_addr_o(waddr_a), .wr_data_o(wdata_a),
        .wr_ack_i(wack), .done_o(done_a));

    rom_selftest_seq #(.ROM_DEPTH(DEPTH), .ROM_SALT(SALT), .GOLD_SIG(int'(GOLD ^ 16'h0001)),
                       .REG_STUCK(1), .DIAG_TMO(TMO)) u1 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ptr_i(ptr),
        .diag_req_o(dreq_b), .diag_ack_i(dack), .diag_fail_i(dfail),
        .wr_req_o(wreq_b), .wr_addr_o(waddr_b), .wr_data_o(wdata_b),
        .wr_ack_i(wack), .done_o(done_b));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(logic [15:0] s, bit rf, bit gf, bit df);
        logic [31:0] w = {s, 16'h0000};
        w[2] = rf; w[3] = gf; w[5] = df; w[12] = rf | gf | df;
        return w;
    endfunction

    typedef struct packed {
        logic [31:0] p; logic [10:0] dly; logic rsp; logic fl; logic [3:0] wk; logic poke;
    } vec_t;
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        {32'h1000_0040, 11'd0,    1'b1, 1'b0, 4'd0, 1'b0},
        {32'h2000_010C, 11'd7,    1'b1, 1'b1, 4'd3, 1'b0},
        {32'h0000_0010, 11'd1023, 1'b1, 1'b0, 4'd1, 1'b0},
        {32'hFFFF_FFF0, 11'd1024, 1'b1, 1'b0, 4'd2, 1'b0},
        {32'h0000_ABC0, 11'd0,    1'b0, 1'b0, 4'd5, 1'b0},
        {32'h3000_0000, 11'd2,    1'b1, 1'b0, 4'd1, 1'b1}
    };

    task automatic run(input vec_t v);
        int n;
        logic [31:0] a0, d0;
        bit df, held;
        df = (!v.rsp || v.dly >= 11'(TMO)) ? 1'b1 : v.fl;
        @(negedge clk); ptr = v.p; start = 1;
        @(negedge clk); start = 0; n = 1;
        while (!dreq_a && n < 500) begin
            @(negedge clk); n++;
            if (v.poke && n == 5) begin ptr = 32'h4444_4440; start = 1; end
            else start = 0;
        end
        chk("R11 diag request latency", n, DEPTH + 6);
        for (int i = 0; i < int'(v.dly); i++) @(negedge clk);
        if (v.rsp) begin
            dack = 1; dfail = v.fl;
            @(negedge clk); dack = 0; dfail = 0;
        end
        while (!wreq_a) @(negedge clk);
        a0 = waddr_a; d0 = wdata_a; held = 1;
        chk("R8 R10 result address", a0, {v.p[31:4], 4'h0});
        chk("R2 R5 R6 R7 result word", d0, exp_word(GOLD, 0, 0, df));
        chk("R3 R4 R7 faulty-instance word", wdata_b, exp_word(GOLD, 1, 1, df));
        for (int k = 0; k < int'(v.wk); k++) begin
            @(negedge clk);
            if (!wreq_a || waddr_a !== a0 || wdata_a !== d0 || done_a) held = 0;
        end
        chk("R8 request held until ack", 32'(held), 32'd1);
        wack = 1;
        @(negedge clk); wack = 0;
        chk("R9 done after ack", {30'd0, done_a, done_b}, 32'd3);
        chk("R9 request dropped", 32'(wreq_a), 32'd0);
        @(negedge clk);
        chk("R9 done one cycle", 32'(done_a), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {29'd0, dreq_a, wreq_a, done_a}, 32'd0);
        rst_n = 1;
        repeat (5) @(negedge clk);
        chk("R1 idle without start", {29'd0, dreq_a, wreq_a, done_a}, 32'd0);
        for (int v = 0; v < NV; v++) run(VECS[v]);
        // reset in the middle of the ROM pass
        @(negedge clk); ptr = 32'h5000_0000; start = 1;
        @(negedge clk); start = 0;
        repeat (10) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk("R1 reset mid-run", {29'd0, dreq_a, wreq_a, done_a}, 32'd0);
        rst_n = 1;
        repeat (DEPTH + 10) @(negedge clk);
        chk("R1 idle after reset", 32'(dreq_a), 32'd0);
        run(VECS[0]);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule